// File: doc/BRIEF.md
# Instruction Fetch Program Counter Unit

This block owns the program counter at the front of a five-stage 32-bit RISC pipeline. Each cycle it presents the current PC as the instruction-memory address, captures the word that memory returns, and loads that word, its PC and a valid flag into the fetch/decode pipeline register. Instruction memory is a combinational read port outside the block.

While reset is held the PC sits at zero. On the first clock edge after release the PC loads a fixed boot address, and from then on it steps by one instruction (4 bytes) per cycle. The decode stage can redirect fetch with a flag and a target address. The PC then takes the target on the next edge, and the word fetched in the same cycle, which lies on the wrong path, is turned into a bubble. A stall request without a redirect freezes both the PC and the fetch/decode register.

Top module: `fetch_pc_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `fetch_pc_o` becomes 0x00000000, `ifid_valid_o` becomes 0 and `ifid_instr_o` becomes the NOP word 0x00000013.
- R2: At the first clock edge after `rst` is released, `fetch_pc_o` loads `BOOT_ADDR` (default 0x00001000). The slot fetched during that boot cycle enters the fetch/decode register with `ifid_valid_o` = 0.
- R3: With no redirect and no stall, `fetch_pc_o` increases by 4 at every edge. The fetch/decode register captures the previous PC on `ifid_pc_o` and the word read at that PC on `ifid_instr_o`, with `ifid_valid_o` = 1.
- R4: When `redirect_i` is high at an edge after boot, the next `fetch_pc_o` is `redirect_target_i` with bits [1:0] cleared, and not PC+4.
- R5: On a redirect, the word fetched in that cycle is discarded: the fetch/decode register takes `ifid_valid_o` = 0 and `ifid_instr_o` = 0x00000013.
- R6: When `stall_i` is high and `redirect_i` is low after boot, `fetch_pc_o`, `ifid_pc_o`, `ifid_instr_o` and `ifid_valid_o` keep their values across the edge.
- R7: When `redirect_i` and `stall_i` are both high, the redirect wins: the PC loads the target and a bubble enters the fetch/decode register.
- R8: `fetch_pc_o[1:0]` is always 0, and `imem_addr_o` always equals `fetch_pc_o`.
- R9: During the boot cycle, `redirect_i` and `stall_i` have no effect: the PC still loads `BOOT_ADDR`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| redirect_i | input | 1 | Taken control transfer detected in decode |
| redirect_target_i | input | 32 | Target address of the redirect |
| stall_i | input | 1 | Hold request from the pipeline control |
| imem_addr_o | output | 32 | Address to instruction memory |
| imem_data_i | input | 32 | Instruction word read at `imem_addr_o` |
| fetch_pc_o | output | 32 | Current fetch PC |
| ifid_pc_o | output | 32 | PC held in the fetch/decode register |
| ifid_instr_o | output | 32 | Instruction held in the fetch/decode register |
| ifid_valid_o | output | 1 | Fetch/decode slot holds a real instruction |

## Verification
The bench drives a redirect and a stall during the boot cycle. A design that honoured them would start at the redirect target or stay at zero instead of at the boot address. It checks that the word fetched alongside a redirect arrives as a NOP with the valid flag cleared, which a design without the one-slot flush would pass on as a live wrong-path instruction. It sends an unaligned target, which a design would carry into the PC if it left bits [1:0] unmasked. It raises redirect and stall together, where giving the stall priority would freeze the PC on the wrong path. It also holds a multi-cycle stall, which a design that kept counting would show as a PC that drifts or a register that changes.

// File: rtl/pcf_pkg.sv
package pcf_pkg;

    localparam int XLEN       = 32;
    localparam int ILEN       = 32;
    localparam int INSTR_BYTES = ILEN / 8;
    localparam int ALIGN_BITS = $clog2(INSTR_BYTES);

    localparam logic [ILEN-1:0] NOP_WORD = 32'h0000_0013;

    typedef enum logic [1:0] {
        PC_BOOT  = 2'd0,
        PC_JUMP  = 2'd1,
        PC_KEEP  = 2'd2,
        PC_STEP  = 2'd3
    } pc_sel_e;

    typedef enum logic [1:0] {
        SLOT_BUBBLE = 2'd0,
        SLOT_LOAD   = 2'd1,
        SLOT_KEEP   = 2'd2
    } slot_act_e;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [ILEN-1:0] instr;
        logic            valid;
    } fd_slot_t;

    function automatic logic [XLEN-1:0] align_pc(input logic [XLEN-1:0] a);
        return {a[XLEN-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
    endfunction

endpackage

// File: rtl/pcf_next_sel.sv
module pcf_next_sel
    import pcf_pkg::*;
(
    input  logic      booted_i,
    input  logic      redirect_i,
    input  logic      stall_i,
    output pc_sel_e   pc_sel_o,
    output slot_act_e slot_act_o
);

    // Priority: boot cycle, then redirect, then stall, then sequential.
    always_comb begin
        if (!booted_i) begin
            pc_sel_o   = PC_BOOT;
            slot_act_o = SLOT_BUBBLE;
        end else if (redirect_i) begin
            pc_sel_o   = PC_JUMP;
            slot_act_o = SLOT_BUBBLE;
        end else if (stall_i) begin
            pc_sel_o   = PC_KEEP;
            slot_act_o = SLOT_KEEP;
        end else begin
            pc_sel_o   = PC_STEP;
            slot_act_o = SLOT_LOAD;
        end
    end

endmodule

// File: rtl/pcf_pc_reg.sv
module pcf_pc_reg
    import pcf_pkg::*;
#(
    parameter logic [XLEN-1:0] BOOT_ADDR = 32'h0000_1000
) (
    input  logic            clk,
    input  logic            rst,
    input  pc_sel_e         pc_sel_i,
    input  logic [XLEN-1:0] target_i,
    output logic [XLEN-1:0] pc_o,
    output logic            booted_o
);

    localparam logic [XLEN-1:0] STEP = XLEN'(INSTR_BYTES);

    logic [XLEN-1:0] pc_q;
    logic            booted_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q     <= '0;
            booted_q <= 1'b0;
        end else begin
            booted_q <= 1'b1;
            unique case (pc_sel_i)
                PC_BOOT: pc_q <= align_pc(BOOT_ADDR);
                PC_JUMP: pc_q <= align_pc(target_i);
                PC_KEEP: pc_q <= pc_q;
                PC_STEP: pc_q <= pc_q + STEP;
                default: pc_q <= pc_q;
            endcase
        end
    end

    assign pc_o     = pc_q;
    assign booted_o = booted_q;

    // R2: the cycle after release loads the boot address
    a_r2_boot_load: assert property (@(posedge clk) disable iff (rst)
        (!booted_q) |=> (pc_q == align_pc(BOOT_ADDR)));

    // R3: sequential step of one instruction
    a_r3_step: assert property (@(posedge clk) disable iff (rst)
        (booted_q && pc_sel_i == PC_STEP) |=> (pc_q == $past(pc_q) + STEP));

    // R8: PC stays instruction aligned
    a_r8_aligned: assert property (@(posedge clk) disable iff (rst)
        pc_q[ALIGN_BITS-1:0] == '0);

endmodule

// File: rtl/pcf_slot_reg.sv
module pcf_slot_reg
    import pcf_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  slot_act_e       act_i,
    input  logic [XLEN-1:0] pc_i,
    input  logic [ILEN-1:0] instr_i,
    output fd_slot_t        slot_o
);

    fd_slot_t slot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '{pc: '0, instr: NOP_WORD, valid: 1'b0};
        end else begin
            unique case (act_i)
                SLOT_BUBBLE: slot_q <= '{pc: pc_i, instr: NOP_WORD, valid: 1'b0};
                SLOT_LOAD:   slot_q <= '{pc: pc_i, instr: instr_i, valid: 1'b1};
                SLOT_KEEP:   slot_q <= slot_q;
                default:     slot_q <= slot_q;
            endcase
        end
    end

    assign slot_o = slot_q;

    // R5: a bubble always carries the NOP word
    a_r5_bubble_nop: assert property (@(posedge clk) disable iff (rst)
        (!slot_q.valid) |-> (slot_q.instr == NOP_WORD));

endmodule

// File: rtl/fetch_pc_unit.sv
module fetch_pc_unit
    import pcf_pkg::*;
#(
    parameter logic [31:0] BOOT_ADDR = 32'h0000_1000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        redirect_i,
    input  logic [31:0] redirect_target_i,
    input  logic        stall_i,
    output logic [31:0] imem_addr_o,
    input  logic [31:0] imem_data_i,
    output logic [31:0] fetch_pc_o,
    output logic [31:0] ifid_pc_o,
    output logic [31:0] ifid_instr_o,
    output logic        ifid_valid_o
);

    pc_sel_e         pc_sel;
    slot_act_e       slot_act;
    logic            booted;
    logic [XLEN-1:0] pc;
    fd_slot_t        slot;

    pcf_next_sel u_sel (
        .booted_i   (booted),
        .redirect_i (redirect_i),
        .stall_i    (stall_i),
        .pc_sel_o   (pc_sel),
        .slot_act_o (slot_act)
    );

    pcf_pc_reg #(.BOOT_ADDR(BOOT_ADDR)) u_pc (
        .clk      (clk),
        .rst      (rst),
        .pc_sel_i (pc_sel),
        .target_i (redirect_target_i),
        .pc_o     (pc),
        .booted_o (booted)
    );

    pcf_slot_reg u_slot (
        .clk     (clk),
        .rst     (rst),
        .act_i   (slot_act),
        .pc_i    (pc),
        .instr_i (imem_data_i),
        .slot_o  (slot)
    );

    assign imem_addr_o  = pc;
    assign fetch_pc_o   = pc;
    assign ifid_pc_o    = slot.pc;
    assign ifid_instr_o = slot.instr;
    assign ifid_valid_o = slot.valid;

    // R4 / R7: a redirect after boot loads the aligned target, stall or not
    a_r4_redirect_target: assert property (@(posedge clk) disable iff (rst)
        (booted && redirect_i) |=> (fetch_pc_o == align_pc($past(redirect_target_i))));

    // R5: the word fetched alongside a redirect is squashed
    a_r5_flush_slot: assert property (@(posedge clk) disable iff (rst)
        (booted && redirect_i) |=> !ifid_valid_o);

    // R6: stall without redirect freezes PC and the fetch/decode slot
    a_r6_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (booted && stall_i && !redirect_i) |=>
            ($stable(fetch_pc_o) && $stable(ifid_instr_o) && $stable(ifid_valid_o)));

endmodule

// File: tb/fetch_pc_unit_bench.sv
module fetch_pc_unit_bench;

    localparam logic [31:0] BOOT = 32'h0000_1000;
    localparam logic [31:0] NOP  = 32'h0000_0013;

    logic        clk = 1'b0;
    logic        rst;
    logic        redirect_i;
    logic [31:0] redirect_target_i;
    logic        stall_i;
    logic [31:0] imem_addr_o;
    logic [31:0] imem_data_i;
    logic [31:0] fetch_pc_o;
    logic [31:0] ifid_pc_o;
    logic [31:0] ifid_instr_o;
    logic        ifid_valid_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;   // 250 MHz

    // Combinational instruction memory model
    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {16'hBE00 ^ a[31:16], a[15:0]} ^ 32'h00A5_0000;
    endfunction
    assign imem_data_i = mem_word(imem_addr_o);

    fetch_pc_unit #(.BOOT_ADDR(BOOT)) u_fetch_pc_unit (
        .clk               (clk),
        .rst               (rst),
        .redirect_i        (redirect_i),
        .redirect_target_i (redirect_target_i),
        .stall_i           (stall_i),
        .imem_addr_o       (imem_addr_o),
        .imem_data_i       (imem_data_i),
        .fetch_pc_o        (fetch_pc_o),
        .ifid_pc_o         (ifid_pc_o),
        .ifid_instr_o      (ifid_instr_o),
        .ifid_valid_o      (ifid_valid_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst = 1'b1; redirect_i = 1'b0; stall_i = 1'b0; redirect_target_i = '0;
        tick(); tick(); tick();
        chk("R1 pc", fetch_pc_o, 32'h0);
        chk("R1 valid", {31'b0, ifid_valid_o}, 32'h0);
        chk("R1 instr", ifid_instr_o, NOP);
    endtask

    task automatic t_boot_ignores_controls();
        rst = 1'b0; redirect_i = 1'b1; redirect_target_i = 32'h0000_5000; stall_i = 1'b1;
        tick();
        chk("R2 R9 boot pc", fetch_pc_o, BOOT);
        chk("R2 boot slot invalid", {31'b0, ifid_valid_o}, 32'h0);
        redirect_i = 1'b0; stall_i = 1'b0;
    endtask

    task automatic t_sequential(input int n);
        for (int i = 0; i < n; i++) begin
            logic [31:0] prev;
            prev = fetch_pc_o;
            tick();
            chk("R3 pc step", fetch_pc_o, prev + 32'd4);
            chk("R3 slot pc", ifid_pc_o, prev);
            chk("R3 slot instr", ifid_instr_o, mem_word(prev));
            chk("R3 slot valid", {31'b0, ifid_valid_o}, 32'h1);
            chk("R8 addr", imem_addr_o, fetch_pc_o);
        end
    endtask

    task automatic t_redirect(input logic [31:0] tgt, input logic with_stall);
        logic [31:0] al;
        al = {tgt[31:2], 2'b00};
        redirect_i = 1'b1; redirect_target_i = tgt; stall_i = with_stall;
        tick();
        redirect_i = 1'b0; stall_i = 1'b0;
        chk(with_stall ? "R7 pc target" : "R4 pc target", fetch_pc_o, al);
        chk("R5 flush valid", {31'b0, ifid_valid_o}, 32'h0);
        chk("R5 flush nop", ifid_instr_o, NOP);
        chk("R8 low bits", {30'b0, fetch_pc_o[1:0]}, 32'h0);
        tick();
        chk("R4 after target", fetch_pc_o, al + 32'd4);
        chk("R4 target fetched", ifid_instr_o, mem_word(al));
        chk("R4 target valid", {31'b0, ifid_valid_o}, 32'h1);
    endtask

    task automatic t_stall(input int n);
        logic [31:0] pc0, spc0, ins0;
        logic v0;
        pc0 = fetch_pc_o; spc0 = ifid_pc_o; ins0 = ifid_instr_o; v0 = ifid_valid_o;
        stall_i = 1'b1;
        for (int i = 0; i < n; i++) begin
            tick();
            chk("R6 pc hold", fetch_pc_o, pc0);
            chk("R6 slot pc hold", ifid_pc_o, spc0);
            chk("R6 slot instr hold", ifid_instr_o, ins0);
            chk("R6 slot valid hold", {31'b0, ifid_valid_o}, {31'b0, v0});
        end
        stall_i = 1'b0;
        tick();
        chk("R6 resume", fetch_pc_o, pc0 + 32'd4);
        chk("R6 resume slot", ifid_pc_o, pc0);
    endtask

    task automatic t_mid_reset();
        rst = 1'b1;
        tick();
        chk("R1 mid pc", fetch_pc_o, 32'h0);
        chk("R1 mid valid", {31'b0, ifid_valid_o}, 32'h0);
        chk("R1 mid instr", ifid_instr_o, NOP);
        rst = 1'b0;
        tick();
        chk("R2 reboot pc", fetch_pc_o, BOOT);
        tick();
        chk("R3 reboot step", fetch_pc_o, BOOT + 32'd4);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        #1;
        t_reset();
        t_boot_ignores_controls();
        t_sequential(8);
        t_redirect(32'h0000_102E, 1'b0);
        t_sequential(3);
        t_stall(3);
        t_redirect(32'h0000_2000, 1'b1);
        t_redirect(32'h0000_0FF0, 1'b0);
        t_sequential(2);
        t_mid_reset();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule